// File: doc/BRIEF.md
# Complementary Current-Mode PWM Gate Core

This block is the digital heart of one current-mode PWM channel that drives a complementary pair of switches: a main gate and its opposite. A one-cycle start pulse from the oscillator opens a switching period by setting the PWM latch. Three synchronous one-bit comparator results end the period early. These are a ramp-over-feedback flag, a first current-limit flag and a second, higher current-limit flag. The analog comparators, slope compensation and error amplifier sit outside the block.

Between the two gates the block inserts a non-overlap gap whose length comes from a register input counted in clock ticks. The gap applies when the main gate turns on and when the complement turns on. If the second current threshold trips, the main gate is blanked for the following two switching periods while the complement keeps conducting. A run input forces both outputs low and returns the channel to its start-up state.

Top module: `cpwm_gate_core`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `gate_o` and `gate_n_o` are both 0.
- R2: `gate_o` turns on only because of a start pulse. From idle with both gates low for longer than the gap, `gate_o` is 1 two clocks after the cycle in which `start_i` is sampled high.
- R3: A ramp flag sampled high ends the on-time, and `gate_o` is 0 two clocks later.
- R4: A first-threshold current-limit flag ends the on-time with the same timing as a ramp flag.
- R5: Reset has priority over set. If a start pulse coincides with any of the three reset flags, no on-time results.
- R6: A second-threshold flag ends the on-time and blanks the next two start pulses. The third start pulse after the trip turns `gate_o` on again.
- R7: A second-threshold trip while blanking is in progress reloads the blanking count to two start pulses.
- R8: After `gate_o` falls, `gate_n_o` rises once both have been low for `dead_i`+1 ticks. A gap value of 0 still leaves one low tick. The two gates are never high together.
- R9: After `gate_n_o` falls for a new on-time, `gate_o` rises once both have been low for `dead_i`+1 ticks.
- R10: Both gates are 0 from the first clock after `run_i` is sampled low.
- R11: After `run_i` rises, both gates stay low until the first start pulse. `gate_n_o` turns on only after a first main on-time has ended, and a reset flag alone does not turn it on.
- R12: While the main gate is blanked by a second-threshold trip, `gate_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Channel run; low holds both gates off |
| start_i | input | 1 | One-cycle period start pulse |
| ramp_trip_i | input | 1 | Ramp above feedback minus offset |
| ilim1_i | input | 1 | First current-limit threshold exceeded |
| ilim2_i | input | 1 | Second current-limit threshold exceeded |
| dead_i | input | DT_W | Non-overlap gap in ticks (gap = value + 1) |
| gate_o | output | 1 | Main gate drive |
| gate_n_o | output | 1 | Complementary gate drive |

## Verification
The hardest state to reach is a second trip that arrives while the blanking count is already partly consumed. Reaching it requires an on-time, a second-threshold trip, one start pulse that decrements the count, and then a new trip before the next start. The stimulus builds this sequence and then counts the start pulses that follow, so it can tell that the count was reloaded rather than allowed to run out. The same sequence runs with the complement held high throughout, so the blanking and gap timings are both observed at the gate pins.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // PWM latch state: on-request and "an on-time has completed since run"
    typedef struct packed {
        logic on;
        logic done;
    } latch_st_t;

endpackage

// File: rtl/cpwm_skip.sv
module cpwm_skip #(
    parameter int SKIP_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic start_i,
    input  logic trip2_i,
    output logic busy_o
);
    localparam int SKW = $clog2(SKIP_N + 1);

    typedef struct packed {
        logic [SKW-1:0] cnt;
    } skip_st_t;

    skip_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (trip2_i) begin
            st_d.cnt = SKW'(SKIP_N);
        end else if (start_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);
endmodule

// File: rtl/cpwm_latch.sv
module cpwm_latch
    import cpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic start_i,
    input  logic skip_i,
    input  logic ramp_i,
    input  logic ilim1_i,
    input  logic ilim2_i,
    output logic main_req_o,
    output logic comp_req_o
);
    latch_st_t st_d, st_q;
    logic      clr_any;

    assign clr_any = ramp_i | ilim1_i | ilim2_i;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else begin
            if (clr_any) begin
                if (st_q.on) st_d.done = 1'b1;
                st_d.on = 1'b0;
            end else if (start_i && !skip_i) begin
                st_d.on = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_req_o = st_q.on;
    assign comp_req_o = st_q.done & ~st_q.on;
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            main_req_i,
    input  logic            comp_req_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            gate_o,
    output logic            gate_n_o
);
    localparam logic [DT_W-1:0] GAP_MAX = '1;

    typedef struct packed {
        logic            g;
        logic            gn;
        logic [DT_W-1:0] gap;
    } dt_st_t;

    dt_st_t st_d, st_q;
    logic   both_low;
    logic   gap_ok;

    assign both_low = ~st_q.g & ~st_q.gn;
    assign gap_ok   = both_low && (st_q.gap >= dead_i);

    always_comb begin
        st_d = st_q;
        if (!both_low)             st_d.gap = '0;
        else if (st_q.gap != GAP_MAX) st_d.gap = st_q.gap + 1'b1;

        st_d.g  = run_i & main_req_i & (st_q.g  | gap_ok);
        st_d.gn = run_i & comp_req_i & (st_q.gn | gap_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o   = st_q.g;
    assign gate_n_o = st_q.gn;
endmodule

// File: rtl/cpwm_gate_core.sv
module cpwm_gate_core #(
    parameter int DT_W   = 4,
    parameter int SKIP_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            start_i,
    input  logic            ramp_trip_i,
    input  logic            ilim1_i,
    input  logic            ilim2_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            gate_o,
    output logic            gate_n_o
);
    logic skip_busy;
    logic main_req;
    logic comp_req;

    cpwm_skip #(.SKIP_N(SKIP_N)) u_skip (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .start_i (start_i),
        .trip2_i (ilim2_i),
        .busy_o  (skip_busy)
    );

    cpwm_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .start_i    (start_i),
        .skip_i     (skip_busy),
        .ramp_i     (ramp_trip_i),
        .ilim1_i    (ilim1_i),
        .ilim2_i    (ilim2_i),
        .main_req_o (main_req),
        .comp_req_o (comp_req)
    );

    cpwm_deadtime #(.DT_W(DT_W)) u_dt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .main_req_i (main_req),
        .comp_req_i (comp_req),
        .dead_i     (dead_i),
        .gate_o     (gate_o),
        .gate_n_o   (gate_n_o)
    );
endmodule

// File: rtl/cpwm_gate_sva.sv
module cpwm_gate_sva (
    input logic clk,
    input logic rst_n,
    input logic run_i,
    input logic start_i,
    input logic ramp_trip_i,
    input logic ilim1_i,
    input logic ilim2_i,
    input logic skip_busy,
    input logic main_req,
    input logic gate_o,
    input logic gate_n_o
);
    p_never_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o && gate_n_o));

    p_run_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!gate_o && !gate_n_o));

    p_on_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_req) |-> $past(start_i));

    p_reset_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (ramp_trip_i || ilim1_i || ilim2_i)) |=> !main_req);

    p_no_on_in_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_req) |-> !$past(skip_busy));

    p_trip2_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && ilim2_i) |=> skip_busy);

    p_gap_before_main_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(!gate_n_o));

    p_gap_before_comp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_n_o) |-> $past(!gate_o));
endmodule

bind cpwm_gate_core cpwm_gate_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .start_i     (start_i),
    .ramp_trip_i (ramp_trip_i),
    .ilim1_i     (ilim1_i),
    .ilim2_i     (ilim2_i),
    .skip_busy   (skip_busy),
    .main_req    (main_req),
    .gate_o      (gate_o),
    .gate_n_o    (gate_n_o)
);

// File: tb/cpwm_gate_core_tb.sv
module cpwm_gate_core_tb;
    localparam int DT_W = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            run_i, start_i, ramp_trip_i, ilim1_i, ilim2_i;
    logic [DT_W-1:0] dead_i;
    logic            gate_o, gate_n_o;

    cpwm_gate_core #(.DT_W(DT_W), .SKIP_N(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .start_i(start_i),
        .ramp_trip_i(ramp_trip_i), .ilim1_i(ilim1_i), .ilim2_i(ilim2_i),
        .dead_i(dead_i), .gate_o(gate_o), .gate_n_o(gate_n_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    at;
        logic  g;
        logic  gn;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    int   t0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares scheduled expectations 2 ns after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].at == cyc) begin
                    n_chk++;
                    if (gate_o !== q[i].g || gate_n_o !== q[i].gn) begin
                        n_err++;
                        $display("FAIL %s cycle %0d: gate/gate_n=%b/%b expected %b/%b",
                                 q[i].tag, cyc, gate_o, gate_n_o, q[i].g, q[i].gn);
                    end
                    q.delete(i);
                end else if (q[i].at < cyc) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL %s cycle %0d: expectation missed, actual %b/%b expected %b/%b",
                             q[i].tag, q[i].at, gate_o, gate_n_o, q[i].g, q[i].gn);
                    q.delete(i);
                end
            end
        end
    end

    task automatic want(input int at, input logic g, input logic gn, input string tag);
        exp_t e;
        e.at = at; e.g = g; e.gn = gn; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one-cycle pulse on the chosen inputs; t0 = cycle in which they were driven
    task automatic fire(input bit s, input bit r, input bit l1, input bit l2);
        t0 = cyc;
        start_i = s; ramp_trip_i = r; ilim1_i = l1; ilim2_i = l2;
        @(negedge clk);
        start_i = 0; ramp_trip_i = 0; ilim1_i = 0; ilim2_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 0; run_i = 0; start_i = 0; ramp_trip_i = 0;
        ilim1_i = 0; ilim2_i = 0; dead_i = 4'd2;
        idle(2);
        want(cyc + 1, 0, 0, "R1");
        want(cyc + 2, 0, 0, "R1");
        idle(3);
        rst_n = 1;
        want(cyc + 1, 0, 0, "R1");
        idle(3);

        // R11: run rises, no start -> both stay low
        run_i = 1;
        want(cyc + 2, 0, 0, "R11");
        want(cyc + 6, 0, 0, "R11");
        idle(8);

        // R2: start from idle -> on two clocks later, held
        fire(1, 0, 0, 0);
        want(t0 + 2, 1, 0, "R2");
        want(t0 + 6, 1, 0, "R2");
        idle(6);

        // R3 / R8: ramp ends on-time, complement after gap of 3 ticks
        fire(0, 1, 0, 0);
        want(t0 + 2, 0, 0, "R3");
        want(t0 + 4, 0, 0, "R8");
        want(t0 + 5, 0, 1, "R8");
        idle(8);

        // R9: start while complement is high
        fire(1, 0, 0, 0);
        want(t0 + 2, 0, 0, "R9");
        want(t0 + 4, 0, 0, "R9");
        want(t0 + 5, 1, 0, "R9");
        idle(8);

        // R4: first current limit ends the period like the ramp
        fire(0, 0, 1, 0);
        want(t0 + 2, 0, 0, "R4");
        want(t0 + 5, 0, 1, "R4");
        idle(8);

        // R5: start together with a reset flag -> no on-time
        fire(1, 1, 0, 0);
        want(t0 + 2, 0, 1, "R5");
        want(t0 + 6, 0, 1, "R5");
        idle(8);

        // R6 / R12: second threshold blanks two starts
        fire(1, 0, 0, 0);
        want(t0 + 5, 1, 0, "R6");
        idle(6);
        fire(0, 0, 0, 1);
        want(t0 + 2, 0, 0, "R6");
        want(t0 + 5, 0, 1, "R6");
        idle(8);
        fire(1, 0, 0, 0);
        want(t0 + 5, 0, 1, "R12");
        idle(8);
        fire(1, 0, 0, 0);
        want(t0 + 5, 0, 1, "R6");
        idle(8);
        fire(1, 0, 0, 0);
        want(t0 + 5, 1, 0, "R6");
        idle(8);

        // R7: retrip during blanking reloads the count
        fire(0, 0, 0, 1);
        want(t0 + 5, 0, 1, "R7");
        idle(8);
        fire(1, 0, 0, 0);
        want(t0 + 5, 0, 1, "R7");
        idle(8);
        fire(0, 0, 0, 1);
        want(t0 + 3, 0, 1, "R12");
        idle(8);
        fire(1, 0, 0, 0);
        want(t0 + 5, 0, 1, "R7");
        idle(8);
        fire(1, 0, 0, 0);
        want(t0 + 5, 0, 1, "R7");
        idle(8);
        fire(1, 0, 0, 0);
        want(t0 + 5, 1, 0, "R7");
        idle(8);

        // R8 / R9 with zero gap register: one tick of separation
        dead_i = 4'd0;
        idle(2);
        fire(0, 1, 0, 0);
        want(t0 + 2, 0, 0, "R8");
        want(t0 + 3, 0, 1, "R8");
        idle(6);
        fire(1, 0, 0, 0);
        want(t0 + 2, 0, 0, "R9");
        want(t0 + 3, 1, 0, "R9");
        idle(6);

        // R10: run low while main is on
        t0 = cyc;
        want(t0 + 1, 0, 0, "R10");
        want(t0 + 3, 0, 0, "R10");
        run_i = 0;
        idle(4);

        // R11: after run returns, a reset flag alone does not raise the complement
        run_i = 1;
        want(cyc + 2, 0, 0, "R11");
        idle(3);
        fire(0, 1, 0, 0);
        want(t0 + 4, 0, 0, "R11");
        idle(6);
        fire(1, 0, 0, 0);
        want(t0 + 2, 1, 0, "R2");
        idle(4);
        fire(0, 1, 0, 0);
        want(t0 + 3, 0, 1, "R8");
        idle(8);

        // R10: run low while complement is on
        t0 = cyc;
        want(t0 + 1, 0, 0, "R10");
        run_i = 0;
        idle(4);
        run_i = 1;
        idle(10);

        finish_run();
    end
endmodule